// File: doc/BRIEF.md
# External Status Change Interrupt Unit

This block watches three modem-control levels (clear-to-send, carrier detect and sync), a break/abort detect level, and two single-cycle event pulses: transmit underrun and the baud-rate counter reaching zero. When an enabled source produces an event, the block latches a single interrupt request. It also freezes a status word that holds the four monitored levels as they stood in the cycle the event was taken.

The break/abort level counts as an event on both edges. External logic can therefore see when a break or abort sequence starts and when it ends, and can time it. Software services the interrupt by reading the frozen status and then issuing a one-cycle clear command. On release, the live levels are compared with the frozen ones. A level that moved while the interrupt was pending therefore raises the request again and is not lost.

All inputs are assumed to be already synchronized to `clk`. Each source has its own enable bit.

Top module: `esc_irq_unit`

## Requirements
- R1: After reset, `irq_o` is 0 and `stat_o` is 4'b0000.
- R2: When no interrupt is pending, a change in either direction on an enabled `cts_i` (`src_en_i[0]`), `dcd_i` (`src_en_i[1]`) or `sync_i` (`src_en_i[2]`) at a clock edge sets `irq_o` from that edge.
- R3: A one-cycle `txund_i` pulse with `src_en_i[4]` set sets `irq_o` from that edge.
- R4: A one-cycle `bzero_i` pulse with `src_en_i[5]` set sets `irq_o` from that edge.
- R5: With `src_en_i[3]` set, both the rising and the falling edge of `brk_i` set `irq_o`.
- R6: A source whose enable bit is 0 never sets `irq_o`. While nothing is pending, `stat_o` follows the live levels, so a change that happened while a source was disabled causes no interrupt after it is enabled.
- R7: `stat_o` bits {3:brk, 2:sync, 1:dcd, 0:cts} show the levels sampled at the edge that set `irq_o`. They stay unchanged for as long as `irq_o` is 1.
- R8: A `clr_i` pulse while `irq_o` is 1 clears `irq_o` at that edge. On the next edge, any enabled level that differs from the frozen `stat_o` sets `irq_o` again.
- R9: An enabled pulse event in the same cycle as `clr_i` keeps `irq_o` at 1.
- R10: A level that changes and then returns to its frozen value while the interrupt is pending causes no new interrupt after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cts_i | input | 1 | Clear-to-send level |
| dcd_i | input | 1 | Carrier-detect level |
| sync_i | input | 1 | Sync input level |
| brk_i | input | 1 | Break/abort detect level |
| txund_i | input | 1 | Transmit underrun pulse |
| bzero_i | input | 1 | Baud counter zero pulse |
| src_en_i | input | 6 | Per-source enables: 0 cts, 1 dcd, 2 sync, 3 brk, 4 underrun, 5 zero count |
| clr_i | input | 1 | Reset-interrupt command pulse |
| irq_o | output | 1 | Latched interrupt request |
| stat_o | output | 4 | Frozen levels {brk, sync, dcd, cts} |

## Verification
The assertions check four properties on every cycle. The status word stays still while the request is pending. An enabled pulse always produces a request. A clear without a coincident pulse always drops the request. A request can only rise after an enabled event.

Other behaviours need directed scenarios and the bench's reference model. These are the re-fire after release when a level moved while latched, and the absence of a re-fire when the level moved back. The same applies to both break edges and to the tracking of disabled sources.

// File: rtl/esc_pkg.sv
package esc_pkg;
    // level sources, bit positions in the status word and enable vector
    localparam int NLVL    = 4;
    localparam int NPUL    = 2;
    localparam int NSRC    = NLVL + NPUL;
    localparam int IX_CTS  = 0;
    localparam int IX_DCD  = 1;
    localparam int IX_SYNC = 2;
    localparam int IX_BRK  = 3;
    // pulse sources, offset inside the pulse group
    localparam int PX_UND  = 0;
    localparam int PX_ZERO = 1;

    typedef struct packed {
        logic            pend;
        logic [NLVL-1:0] snap;
    } esc_state_t;
endpackage

// File: rtl/esc_lvl_cmp.sv
module esc_lvl_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] ref_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] hit_o
);
    // one comparator per level source; either direction counts
    for (genvar g = 0; g < W; g++) begin : g_cmp
        assign hit_o[g] = en_i[g] & (live_i[g] ^ ref_i[g]);
    end
endmodule

// File: rtl/esc_pul_gate.sv
module esc_pul_gate #(
    parameter int W = 2
) (
    input  logic [W-1:0] pul_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] hit_o
);
    for (genvar g = 0; g < W; g++) begin : g_gate
        assign hit_o[g] = en_i[g] & pul_i[g];
    end
endmodule

// File: rtl/esc_irq_unit.sv
module esc_irq_unit
    import esc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cts_i,
    input  logic            dcd_i,
    input  logic            sync_i,
    input  logic            brk_i,
    input  logic            txund_i,
    input  logic            bzero_i,
    input  logic [NSRC-1:0] src_en_i,
    input  logic            clr_i,
    output logic            irq_o,
    output logic [NLVL-1:0] stat_o
);
    esc_state_t st_d, st_q;

    logic [NLVL-1:0] live;
    logic [NPUL-1:0] pul;
    logic [NLVL-1:0] lvl_hit;
    logic [NPUL-1:0] pul_hit;
    logic            lvl_fire_d;
    logic            pul_fire_d;

    always_comb begin
        live          = '0;
        live[IX_CTS]  = cts_i;
        live[IX_DCD]  = dcd_i;
        live[IX_SYNC] = sync_i;
        live[IX_BRK]  = brk_i;
        pul           = '0;
        pul[PX_UND]   = txund_i;
        pul[PX_ZERO]  = bzero_i;
    end

    esc_lvl_cmp #(.W(NLVL)) u_lvl (
        .live_i (live),
        .ref_i  (st_q.snap),
        .en_i   (src_en_i[NLVL-1:0]),
        .hit_o  (lvl_hit)
    );

    esc_pul_gate #(.W(NPUL)) u_pul (
        .pul_i  (pul),
        .en_i   (src_en_i[NSRC-1:NLVL]),
        .hit_o  (pul_hit)
    );

    always_comb begin
        st_d       = st_q;
        // level compare is only live while nothing is latched
        lvl_fire_d = (|lvl_hit) & ~st_q.pend;
        pul_fire_d = |pul_hit;
        if (!st_q.pend) begin
            st_d.snap = live;
        end
        if (clr_i) begin
            st_d.pend = 1'b0;
        end
        if (lvl_fire_d || pul_fire_d) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.pend;
    assign stat_o = st_q.snap;

    // R7
    stat_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> $stable(stat_o));

    // R3
    pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pul & src_en_i[NSRC-1:NLVL])) |=> irq_o);

    // R8
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && clr_i && !(|(pul & src_en_i[NSRC-1:NLVL]))) |=> !irq_o);

    // R6
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !(|(pul & src_en_i[NSRC-1:NLVL]))
                && !(|((live ^ stat_o) & src_en_i[NLVL-1:0]))) |=> !irq_o);
endmodule

// File: tb/esc_irq_unit_test.sv
module esc_irq_unit_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       cts = 0, dcd = 0, syn = 0, brk = 0, und = 0, bz = 0, clr = 0;
    logic [5:0] en = 6'h3f;
    logic       irq;
    logic [3:0] stat;

    int n_run = 0, n_fail = 0;
    bit m_pend = 0;
    bit [3:0] m_snap = 0;

    always #2.5 clk = ~clk;

    esc_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .cts_i(cts), .dcd_i(dcd), .sync_i(syn),
        .brk_i(brk), .txund_i(und), .bzero_i(bz), .src_en_i(en),
        .clr_i(clr), .irq_o(irq), .stat_o(stat)
    );

    // behavioural reference: pending flag plus held levels
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 0;
            m_snap = 0;
        end else begin
            bit [3:0] lv;
            bit ev;
            bit nxt;
            lv = {brk, syn, dcd, cts};
            ev = (en[4] && und) || (en[5] && bz);
            if (!m_pend)
                for (int i = 0; i < 4; i++)
                    if (en[i] && lv[i] != m_snap[i]) ev = 1;
            nxt = m_pend && !clr;
            if (ev) nxt = 1;
            if (!m_pend) m_snap = lv;
            m_pend = nxt;
        end
    end

    always @(negedge clk) if (rst_n) begin
        n_run++;
        if (irq !== m_pend || stat !== m_snap) begin
            n_fail++;
            $display("FAIL R7 model: irq=%0b stat=%b expected irq=%0b stat=%b",
                     irq, stat, m_pend, m_snap);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, bit i_exp, logic [3:0] s_exp);
        n_run++;
        if (irq !== i_exp || stat !== s_exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b stat=%b expected irq=%0b stat=%b",
                     req, irq, stat, i_exp, s_exp);
        end
    endtask

    task automatic clear();
        clr = 1; tick(); clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 0, 4'b0000);
        rst_n = 1;
        tick();
        chk("R1", 0, 4'b0000);

        // R2 rising cts, then dcd moves while pending (R7)
        cts = 1; tick();
        chk("R2", 1, 4'b0001);
        dcd = 1; tick();
        chk("R7", 1, 4'b0001);
        clear();
        chk("R8", 0, 4'b0001);
        tick();
        chk("R8", 1, 4'b0011);
        clear(); tick();
        chk("R8", 0, 4'b0011);

        // R2 falling edge on sync after a rise
        syn = 1; tick();
        chk("R2", 1, 4'b0111);
        clear(); tick();
        syn = 0; tick();
        chk("R2", 1, 4'b0011);
        clear(); tick();

        // R10 excursion and return while latched
        cts = 0; tick();
        chk("R10", 1, 4'b0010);
        cts = 1; tick();
        cts = 0; tick();
        clear(); tick();
        chk("R10", 0, 4'b0010);

        // R3 underrun pulse
        und = 1; tick(); und = 0;
        chk("R3", 1, 4'b0010);
        clear(); tick();
        chk("R3", 0, 4'b0010);

        // R4 zero-count pulse
        bz = 1; tick(); bz = 0;
        chk("R4", 1, 4'b0010);
        clear();

        // R5 break start and end
        brk = 1; tick();
        chk("R5", 1, 4'b1010);
        clear(); tick();
        chk("R5", 0, 4'b1010);
        brk = 0; tick();
        chk("R5", 1, 4'b0010);
        clear(); tick();

        // R9 pulse coincides with clear
        bz = 1; tick(); bz = 0;
        chk("R9", 1, 4'b0010);
        und = 1; clr = 1; tick(); und = 0; clr = 0;
        chk("R9", 1, 4'b0010);
        clear(); tick();
        chk("R9", 0, 4'b0010);

        // R6 everything disabled: no request, status tracks live levels
        en = 6'h00;
        cts = 1; dcd = 0; syn = 1; brk = 1; und = 1; bz = 1; tick();
        und = 0; bz = 0;
        chk("R6", 0, 4'b1101);
        tick();
        en = 6'h3f; tick();
        chk("R6", 0, 4'b1101);
        // only dcd enabled; cts change ignored, dcd change taken
        en = 6'h02; cts = 0; tick();
        chk("R6", 0, 4'b1100);
        dcd = 1; tick();
        chk("R6", 1, 4'b1110);
        clear(); tick();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule